// File: doc/BRIEF.md
# Four-Channel Triggered Waveform Capture

This block records a window of samples from four ADC channels so that a host can inspect raw waveforms while the acquisition card is being debugged. All four channels share one input stream. Each stream word carries one sample per channel. The stream is first thinned by an integer divider. The kept samples go into a circular record buffer. A level trigger, watching one chosen channel, freezes a record that holds a programmable number of samples before the trigger point.

Three trigger behaviours are offered:
- **Single:** capture once and then wait for a new arm.
- **Normal:** capture again on its own after each record has been read.
- **Auto:** like normal, but it also forces a capture when no trigger edge arrives within a time limit.

When a record is complete, the block streams it out oldest sample first over a valid/ready interface.

The sample input has no ready signal, because an ADC cannot be stalled. A word with `in_valid` high is always consumed, and it is simply dropped whenever no capture is in progress. The readout side honours back-pressure: while `rd_valid` is high and `rd_ready` is low, the word and its last flag are held. A word is transferred on a clock edge where both are high. The configuration inputs must be held steady while a capture is in progress.

Top module: `scope_capture`

## Requirements
- R1: While reset is applied, and in the first cycle after it, `done`, `rd_valid` and `rd_last` are low.
- R2: After arming, decimated sample j (counted from 0) is the valid input word with index j*D among the words received after arming, where D is `cfg_div` and 0 is treated as 1. Words with `in_valid` low, and words presented in the arming cycle or while idle, are not recorded.
- R3: Channel k occupies bits [16k+15:16k] of a sample word. A trigger is an unsigned rising crossing on channel `cfg_src`: the previous decimated sample is below `cfg_thresh` and the current one is at or above it.
- R4: A trigger is accepted only when at least `cfg_pre` decimated samples have been recorded since arming.
- R5: A record is 1024 words read in time order. It holds the `cfg_pre` samples before the trigger sample, then the trigger sample, then the samples after it. `rd_last` is high on the 1024th word only.
- R6: `done` and `rd_valid` rise when the last post-trigger sample is written and stay high until the final word is accepted. Input samples arriving in that time do not change the record.
- R7: While `rd_valid` is high and `rd_ready` is low, `rd_data` and `rd_last` stay unchanged in the next cycle.
- R8: In single mode (`cfg_mode`=1), the block goes idle after the final word is read. It records nothing and never raises `done` until `arm` is pulsed again.
- R9: In normal mode (`cfg_mode`=2, or 3, which behaves the same), the block re-arms by itself on the edge that accepts the final word.
- R10: In auto mode (`cfg_mode`=0), the block behaves as in normal mode. In addition, the first decimated sample that arrives after `cfg_timeout` clock cycles of waiting becomes the trigger, provided R4 holds. With one valid word per cycle and D=1, the forced trigger is decimated sample max(`cfg_timeout`, `cfg_pre`).
- R11: `arm` has no effect while a capture or a readout is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample word present |
| in_data | input | 64 | Four 16-bit channel samples, channel 0 in the low bits |
| cfg_mode | input | 2 | 0 auto, 1 single, 2 or 3 normal |
| cfg_div | input | 16 | Decimation divider |
| cfg_src | input | 2 | Trigger source channel |
| cfg_thresh | input | 16 | Trigger level (unsigned) |
| cfg_pre | input | 10 | Samples kept before the trigger |
| cfg_timeout | input | 24 | Auto-mode wait limit in clock cycles |
| arm | input | 1 | Start a capture from idle (pulse) |
| done | output | 1 | Record complete and awaiting readout |
| rd_valid | output | 1 | Readout word valid |
| rd_ready | input | 1 | Host accepts readout word |
| rd_data | output | 64 | Readout word, same layout as `in_data` |
| rd_last | output | 1 | Final word of the record |

## Verification
Most internal faults show up as a misaligned record rather than a hang:
- **Write pointer or divider fault:** a wrong write pointer or divider state shifts the ramp carried on channel 3 within the first word read back.
- **Trigger fault:** a trigger qualified too early or on the wrong edge moves the record start by whole sawtooth periods.
- **Post-trigger counter fault:** an off-by-one in the post-trigger count breaks the time order at the wrap point, or moves `rd_last`.
- **Mode logic fault:** faults in the mode logic appear one record later, as a missing or unwanted `done` after the final handshake.

// File: rtl/scope_pkg.sv
package scope_pkg;
  typedef enum logic [1:0] {
    MODE_AUTO   = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_NORMAL = 2'd2,
    MODE_NORM_B = 2'd3
  } scope_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_POST = 2'd2,
    ST_READ = 2'd3
  } scope_state_e;
endpackage

// File: rtl/scope_decim.sv
// Keeps one valid input word out of every div; restart aligns to the next word.
module scope_decim #(
  parameter int DIVW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            in_valid,
  input  logic [DIVW-1:0] div,
  output logic            take
);
  logic [DIVW-1:0] cnt;
  logic [DIVW:0]   nxt;

  assign nxt  = {1'b0, cnt} + 1'b1;
  assign take = in_valid && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (in_valid) begin
      cnt <= (nxt >= {1'b0, div}) ? '0 : nxt[DIVW-1:0];
    end
  end
endmodule

// File: rtl/scope_trig.sv
// Rising-crossing detector on consecutive decimated samples of one channel.
module scope_trig #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          take,
  input  logic [DW-1:0] cur,
  input  logic [DW-1:0] thresh,
  output logic          hit
);
  logic [DW-1:0] prev;
  logic          prev_ok;

  assign hit = take && prev_ok && (prev < thresh) && (cur >= thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= '0;
      prev_ok <= 1'b0;
    end else if (restart) begin
      prev_ok <= 1'b0;
    end else if (take) begin
      prev    <= cur;
      prev_ok <= 1'b1;
    end
  end
endmodule

// File: rtl/scope_ram.sv
// Record buffer: one write port, combinational read port.
module scope_ram #(
  parameter int W  = 64,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/scope_capture.sv
module scope_capture
  import scope_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int DW   = 16,
  parameter int AW   = 10,
  parameter int DIVW = 16,
  parameter int TOW  = 24,
  parameter int SW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [NCH*DW-1:0] in_data,
  input  logic [1:0]        cfg_mode,
  input  logic [DIVW-1:0]   cfg_div,
  input  logic [SW-1:0]     cfg_src,
  input  logic [DW-1:0]     cfg_thresh,
  input  logic [AW-1:0]     cfg_pre,
  input  logic [TOW-1:0]    cfg_timeout,
  input  logic              arm,
  output logic              done,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [NCH*DW-1:0] rd_data,
  output logic              rd_last
);
  localparam int WW = NCH * DW;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] LAST_IDX = '1;
  localparam logic [AW:0]   FULL = (AW+1)'(DEPTH);

  logic [DW-1:0] chan [NCH];
  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign chan[g] = in_data[g*DW +: DW];
  end

  scope_state_e  state;
  scope_mode_e   mode;
  logic [DW-1:0] src_smp;
  logic          dec_take, take, hit, restart, trig_ok, pre_met, tmo_hit;
  logic          rd_fire, rd_end, capturing;
  logic [AW-1:0] wptr, trig_addr, post_left, rptr, rcnt;
  logic [AW:0]   fill;
  logic [TOW-1:0] tmo;

  assign mode      = scope_mode_e'(cfg_mode);
  assign src_smp   = chan[cfg_src];
  assign capturing = (state == ST_PRE) || (state == ST_POST);
  assign take      = capturing && dec_take;
  assign pre_met   = fill >= {1'b0, cfg_pre};
  assign tmo_hit   = (mode == MODE_AUTO) && (tmo >= cfg_timeout);
  assign trig_ok   = (state == ST_PRE) && take && pre_met && (hit || tmo_hit);
  assign rd_fire   = (state == ST_READ) && rd_ready;
  assign rd_end    = rd_fire && (rcnt == LAST_IDX);
  assign restart   = ((state == ST_IDLE) && arm) || (rd_end && (mode != MODE_SINGLE));

  assign rd_valid = (state == ST_READ);
  assign done     = (state == ST_READ);
  assign rd_last  = (state == ST_READ) && (rcnt == LAST_IDX);

  scope_decim #(.DIVW(DIVW)) u_decim (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .in_valid (in_valid),
    .div      (cfg_div),
    .take     (dec_take)
  );

  scope_trig #(.DW(DW)) u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .take    (take),
    .cur     (src_smp),
    .thresh  (cfg_thresh),
    .hit     (hit)
  );

  scope_ram #(.W(WW), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (take),
    .waddr (wptr),
    .wdata (in_data),
    .raddr (rptr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wptr      <= '0;
      fill      <= '0;
      tmo       <= '0;
      trig_addr <= '0;
      post_left <= '0;
      rptr      <= '0;
      rcnt      <= '0;
    end else begin
      if (take) wptr <= wptr + 1'b1;
      case (state)
        ST_IDLE: begin
          if (arm) begin
            state <= ST_PRE;
            fill  <= '0;
            tmo   <= '0;
          end
        end
        ST_PRE: begin
          if (tmo != '1) tmo <= tmo + 1'b1;
          if (take && (fill != FULL)) fill <= fill + 1'b1;
          if (trig_ok) begin
            trig_addr <= wptr;
            post_left <= LAST_IDX - cfg_pre;
            if (cfg_pre == LAST_IDX) begin
              state <= ST_READ;
              rptr  <= wptr - cfg_pre;
              rcnt  <= '0;
            end else begin
              state <= ST_POST;
            end
          end
        end
        ST_POST: begin
          if (take) begin
            post_left <= post_left - 1'b1;
            if (post_left == AW'(1)) begin
              state <= ST_READ;
              rptr  <= trig_addr - cfg_pre;
              rcnt  <= '0;
            end
          end
        end
        ST_READ: begin
          if (rd_fire) begin
            rptr <= rptr + 1'b1;
            rcnt <= rcnt + 1'b1;
            if (rcnt == LAST_IDX) begin
              if (mode == MODE_SINGLE) begin
                state <= ST_IDLE;
              end else begin
                state <= ST_PRE;
                fill  <= '0;
                tmo   <= '0;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scope_capture_chk.sv
module scope_capture_chk #(
  parameter int WW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cfg_mode,
  input logic          done,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [WW-1:0] rd_data,
  input logic          rd_last
);
  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_last)));

  // R5
  last_in_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);

  // R6
  done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(rd_valid && rd_ready && rd_last));

  // R8
  single_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && rd_last && cfg_mode == 2'd1) |=> !done);

  // R9
  rearm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && rd_last && cfg_mode != 2'd1) |=> !done);
endmodule

bind scope_capture scope_capture_chk #(.WW(NCH*DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_mode (cfg_mode),
  .done     (done),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_data  (rd_data),
  .rd_last  (rd_last)
);

// File: tb/tb_scope_capture.sv
module tb_scope_capture;
  localparam int DEPTH = 1024;
  localparam int WW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [WW-1:0] in_data = '0;
  logic [1:0]    cfg_mode = 2'd1;
  logic [15:0]   cfg_div = 16'd1;
  logic [1:0]    cfg_src = 2'd0;
  logic [15:0]   cfg_thresh = 16'd0;
  logic [9:0]    cfg_pre = 10'd0;
  logic [23:0]   cfg_timeout = 24'hFFFFFF;
  logic          arm = 1'b0;
  logic          done, rd_valid, rd_ready, rd_last;
  logic [WW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  int per[3], off[3], slope[3];

  always #2 clk = ~clk;

  scope_capture dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .cfg_mode(cfg_mode), .cfg_div(cfg_div), .cfg_src(cfg_src),
    .cfg_thresh(cfg_thresh), .cfg_pre(cfg_pre), .cfg_timeout(cfg_timeout),
    .arm(arm), .done(done), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_last(rd_last)
  );

  initial rd_ready = 1'b0;

  function automatic logic [WW-1:0] vec(int n);
    logic [WW-1:0] r;
    for (int k = 0; k < 3; k++) begin
      int v;
      v = ((n + off[k]) % per[k]) * slope[k];
      r[k*16 +: 16] = v[15:0];
    end
    r[63:48] = n[15:0];
    return r;
  endfunction

  function automatic int chval(int n, int k);
    logic [WW-1:0] w;
    w = vec(n);
    return int'(w[k*16 +: 16]);
  endfunction

  // R3 R4: first accepted rising crossing, in decimated sample units
  function automatic int find_trig(int src, int thr, int pre, int div);
    for (int j = (pre > 1 ? pre : 1); j < 100000; j++) begin
      if (chval((j-1)*div, src) < thr && chval(j*div, src) >= thr) return j;
    end
    return -1;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic new_wave(int src, bit flat);
    for (int k = 0; k < 3; k++) begin
      per[k]   = 20 + int'($urandom % 150);
      off[k]   = int'($urandom % per[k]);
      slope[k] = 60000 / per[k];
    end
    if (flat) begin
      per[src] = 1; off[src] = 0; slope[src] = 0;
      cfg_thresh = 16'd1000;
    end else begin
      cfg_thresh = 16'(slope[src] * (2 + int'($urandom % (per[src] - 4))));
    end
    cfg_src = 2'(src);
  endtask

  task automatic do_arm();
    @(negedge clk);
    arm = 1'b1;
    in_valid = 1'b0;
    @(posedge clk);
  endtask

  task automatic acquire(int gap, int glitch, string req, output bit got);
    int n = 0;
    got = 1'b0;
    for (int c = 0; c < 40000; c++) begin
      bit v;
      @(negedge clk);
      v = (int'($urandom % 100) >= gap);
      arm = (c == glitch);
      in_valid = v;
      in_data = vec(n);
      @(posedge clk);
      if (v) n++;
      #1;
      if (done) begin got = 1'b1; break; end
    end
    check(got, req, "done raised after capture", longint'(got), 1);
  endtask

  task automatic readout(int start, int div, int rdy_pct, string req);
    int i = 0, mism = 0, lastbad = 0, holdbad = 0, novalid = 0;
    bit pend = 1'b0;
    logic [WW-1:0] pend_d, first_got, first_exp;
    first_got = '0; first_exp = '0;
    for (int c = 0; c < 20000 && i < DEPTH; c++) begin
      @(negedge clk);
      arm = 1'b0;
      rd_ready = (int'($urandom % 100) < rdy_pct);
      in_valid = $urandom % 2;
      in_data = {$urandom, $urandom};
      #1;
      if (!rd_valid) novalid++;
      else begin
        if (pend && rd_data != pend_d) holdbad++;
        if (rd_ready) begin
          logic [WW-1:0] e;
          e = vec((start + i) * div);
          if (rd_data != e) begin
            if (mism == 0) begin first_got = rd_data; first_exp = e; end
            mism++;
          end
          if (rd_last != (i == DEPTH-1)) lastbad++;
          i++;
          pend = 1'b0;
        end else begin
          pend = 1'b1;
          pend_d = rd_data;
        end
      end
      @(posedge clk);
    end
    #1;
    rd_ready = 1'b0;
    check(mism == 0 && i == DEPTH, {req, " R5"}, "record content", longint'(first_got), longint'(first_exp));
    check(lastbad == 0, "R5", "rd_last misplaced count", lastbad, 0);
    check(holdbad == 0, "R7", "word changed under back-pressure", holdbad, 0);
    check(novalid == 0, "R6", "rd_valid low during readout", novalid, 0);
  endtask

  task automatic run_case(int div, int gap, int pre, int src, bit flat, int jfix,
                          int glitch, int rdy, string req);
    bit got;
    int j;
    cfg_div = 16'(div);
    cfg_pre = 10'(pre);
    new_wave(src, flat);
    acquire(gap, glitch, req, got);
    j = (jfix >= 0) ? jfix : find_trig(src, int'(cfg_thresh), pre, div);
    if (got) readout(j - pre, div, rdy, req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1;
    check(!done && !rd_valid && !rd_last, "R1", "outputs in reset", {done, rd_valid, rd_last}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(!done && !rd_valid && !rd_last, "R1", "outputs after reset", {done, rd_valid, rd_last}, 0);

    // R8 single shot, R2 R3 basic
    cfg_mode = 2'd1;
    cfg_timeout = 24'hFFFFFF;
    cfg_div = 16'd1; cfg_pre = 10'd100;
    new_wave(0, 1'b0);
    do_arm();
    run_case(1, 0, 100, 0, 1'b0, -1, -1, 100, "R2 R3");

    // R8: idle after single record, samples ignored
    cnt = 0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data = vec(c);
      #1;
      if (done || rd_valid) cnt++;
    end
    check(cnt == 0, "R8", "done while idle in single mode", cnt, 0);

    // R11 arm pulse mid-capture, R2 decimation with gaps
    cfg_mode = 2'd2;
    cfg_div = 16'd3; cfg_pre = 10'(1 + $urandom % 900);
    new_wave(1, 1'b0);
    do_arm();
    run_case(3, 30, int'(cfg_pre), 1, 1'b0, -1, 200, 60, "R11 R2");

    // R9 self re-arm, pre boundary 0
    run_case(2, 0, 0, 2, 1'b0, -1, -1, 70, "R9");
    // pre boundary at the top of the range
    run_case(1, 10, 1023, 0, 1'b0, -1, -1, 80, "R4");
    // R4 crossings long before the pre depth is filled
    cfg_div = 16'd1; cfg_pre = 10'd600;
    new_wave(1, 1'b0);
    per[1] = 30; off[1] = 0; slope[1] = 2000; cfg_thresh = 16'd21000;
    begin
      bit got;
      acquire(0, -1, "R4", got);
      if (got) readout(find_trig(1, 21000, 600, 1) - 600, 1, 90, "R4");
    end

    // R10 auto mode with real crossings
    cfg_mode = 2'd0;
    cfg_timeout = 24'hFFFFFF;
    run_case(2, 20, 300, 2, 1'b0, -1, -1, 75, "R10");
    // R10 forced trigger: timeout dominates
    cfg_timeout = 24'd300;
    run_case(1, 0, 50, 0, 1'b1, 300, -1, 100, "R10");
    // R10 forced trigger: pre depth dominates
    cfg_timeout = 24'd10;
    run_case(1, 0, 200, 1, 1'b1, 200, -1, 85, "R10");

    // random normal-mode records, modes 2 and 3
    for (int t = 0; t < 3; t++) begin
      int d, p, s;
      cfg_mode = 2'(2 + ($urandom % 2));
      cfg_timeout = 24'hFFFFFF;
      d = 1 + int'($urandom % 5);
      p = int'($urandom % 1024);
      s = int'($urandom % 3);
      run_case(d, int'($urandom % 40), p, s, 1'b0, -1, -1, 50 + int'($urandom % 50), "R9 R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule